// File: doc/BRIEF.md
# Pulse Waveform Comparator

This block turns one voice's phase accumulator into a two-level pulse wave. A 12-bit pulse width, loaded through two byte-wide register writes, is compared against the top 12 bits of the 24-bit accumulator. The output word has all twelve bits high while the accumulator top is at or above the width, and all bits low otherwise. A test input forces the output high.

The comparison is the carry out of a ripple chain. The chain adds the accumulator top, the bitwise complement of the width and a forced carry-in of one, which is the same as subtracting the width. A carry out therefore means the accumulator top is greater than or equal to the width.

A two-state sequencer takes the result across two clocks for each sample. A sample strobe in state `ST_IDLE` latches the chain's carry and moves to `ST_EVAL` (transition *accept*). In `ST_EVAL` the latched carry is ORed with the test input and loaded into the output register, and the sequencer always goes back to `ST_IDLE` (transition *publish*). The output therefore lags the accumulator by one sample. A strobe that arrives while the sequencer is in `ST_EVAL` is dropped.

Top module: `pulse_wave_gen`

## Requirements
- R1: After reset, `pulse_o` is 0x000, the sequencer is in `ST_IDLE` and the pulse width is zero.
- R2: A write with `wr_addr_i` = 2 loads `wr_data_i[7:0]` into width bits 7:0.
- R3: A write with `wr_addr_i` = 3 loads `wr_data_i[3:0]` into width bits 11:8. Data bits 7:4 of that write are ignored.
- R4: A write to any address other than 2 or 3 leaves the pulse width unchanged.
- R5: With the test input low, a published sample is 0xFFF when `acc_i[23:12]` >= width, and 0x000 otherwise.
- R6: `pulse_o` changes only on the clock edge that leaves `ST_EVAL`. A strobe accepted at edge k shows its result after edge k+1.
- R7: If `test_i` is high at the publish edge, the published value is 0xFFF whatever the comparison gives.
- R8: A strobe asserted while the sequencer is in `ST_EVAL` is ignored. The output keeps the result of the strobe that was accepted.
- R9: `pulse_o` is always either 0x000 or 0xFFF.
- R10: With a width of zero and the test input low, every accumulator value publishes 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Sample strobe |
| acc_i | input | 24 | Phase accumulator value |
| test_i | input | 1 | Forces the output high |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 8 | Register write data |
| pulse_o | output | 12 | Pulse waveform word |

## Verification
The hardest case to reach is a strobe that lands on the one clock the sequencer spends in `ST_EVAL`. The bench holds the strobe high for two consecutive clocks and changes the accumulator to a value on the other side of the width in the second clock. It then checks that the published word still belongs to the first value. Every accumulator top value is swept against widths that sit at the edges of the range and of the byte split, so each comparison boundary is crossed in both directions.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
    localparam int PW_BITS   = 12;
    localparam int ACC_BITS  = 24;
    localparam int ADDR_BITS = 5;
    localparam int DATA_BITS = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } seq_state_t;
endpackage

// File: rtl/pulse_width_regs.sv
module pulse_width_regs #(
    parameter int PW_W   = 12,
    parameter int DW     = 8,
    parameter int AW     = 5,
    parameter int LO_OFS = 2,
    parameter int HI_OFS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [PW_W-1:0] width_o
);
    localparam int HI_W = PW_W - DW;

    logic [DW-1:0]   lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == AW'(LO_OFS)) lo_q <= wr_data_i;
            if (wr_addr_i == AW'(HI_OFS)) hi_q <= wr_data_i[HI_W-1:0];
        end
    end

    assign width_o = {hi_q, lo_q};

    // R4: writes to other addresses do not touch the width
    assert_foreign_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != AW'(LO_OFS) && wr_addr_i != AW'(HI_OFS)) |=> $stable(width_o));
endmodule

// File: rtl/pulse_carry_chain.sv
module pulse_carry_chain #(
    parameter int W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         ge_o
);
    logic [W:0]   c;
    logic [W-1:0] nb;

    assign nb   = ~b_i;
    assign c[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign c[i+1] = (a_i[i] & nb[i]) | (c[i] & (a_i[i] | nb[i]));
    end

    assign ge_o = c[W];

    // R5: the ripple carry agrees with a magnitude comparison
    always_comb begin
        assert_carry_ge_R5: assert (ge_o == (a_i >= b_i));
    end
endmodule

// File: rtl/pulse_wave_gen.sv
module pulse_wave_gen
    import pulse_pkg::*;
#(
    parameter int PW_W   = PW_BITS,
    parameter int ACC_W  = ACC_BITS,
    parameter int AW     = ADDR_BITS,
    parameter int DW     = DATA_BITS,
    parameter int LO_OFS = 2,
    parameter int HI_OFS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             test_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [PW_W-1:0]  pulse_o
);
    localparam logic [PW_W-1:0] ALL_ONES = '1;

    logic [PW_W-1:0] width;
    logic [PW_W-1:0] acc_top;
    logic            ge;
    logic            carry_q;
    seq_state_t      state_q, state_d;

    assign acc_top = acc_i[ACC_W-1 -: PW_W];

    pulse_width_regs #(
        .PW_W(PW_W), .DW(DW), .AW(AW), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .width_o(width)
    );

    pulse_carry_chain #(.W(PW_W)) u_chain (
        .a_i(acc_top), .b_i(width), .ge_o(ge)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (step_i) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            pulse_o <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (step_i) carry_q <= ge;
                ST_EVAL: pulse_o <= {PW_W{carry_q | test_i}};
            endcase
        end
    end

    assert_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o == '0) || (pulse_o == ALL_ONES));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> $stable(pulse_o));

    assert_test_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && test_i) |=> (pulse_o == ALL_ONES));

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |=> (state_q == ST_IDLE) && $stable(carry_q));
endmodule

// File: tb/pulse_wave_gen_tb.sv
module pulse_wave_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [23:0] acc_i = '0;
    logic        test_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [11:0] pulse_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pulse_wave_gen u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .acc_i(acc_i),
        .test_i(test_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .pulse_o(pulse_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_width(input logic [11:0] w);
        reg_write(5'd2, w[7:0]);
        reg_write(5'd3, {4'h0, w[11:8]});
    endtask

    function automatic logic [11:0] model(input logic [11:0] top, input logic [11:0] w, input logic t);
        return (t || top >= w) ? 12'hFFF : 12'h000;
    endfunction

    task automatic sample(input logic [11:0] top, input logic t);
        @(negedge clk);
        acc_i = {top, 12'h5A3}; test_i = t; step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [11:0] widths [6];
        widths[0] = 12'h000; widths[1] = 12'h001; widths[2] = 12'h0FF;
        widths[3] = 12'h100; widths[4] = 12'h800; widths[5] = 12'hFFF;

        repeat (3) @(negedge clk);
        check("R1 reset output", pulse_o, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output after release", pulse_o, 12'h000);
        sample(12'h000, 1'b0);
        check("R1 width zero after reset", pulse_o, 12'hFFF);

        for (int p = 0; p < 6; p++) begin
            set_width(widths[p]);
            for (int a = 0; a < 4096; a++) begin
                sample(12'(a), 1'b0);
                if (p == 0) check("R10 zero width", pulse_o, 12'hFFF);
                else        check("R5 compare sweep", pulse_o, model(12'(a), widths[p], 1'b0));
            end
        end

        set_width(12'h800);
        for (int a = 0; a < 4096; a += 37) begin
            sample(12'(a), 1'b1);
            check("R7 test force", pulse_o, 12'hFFF);
        end

        // R2: low byte alone
        reg_write(5'd2, 8'h40);
        sample(12'h83F, 1'b0); check("R2 low byte below", pulse_o, 12'h000);
        sample(12'h840, 1'b0); check("R2 low byte at", pulse_o, 12'hFFF);

        // R3: upper data nibble ignored
        reg_write(5'd3, 8'hF5);
        sample(12'h53F, 1'b0); check("R3 high nibble below", pulse_o, 12'h000);
        sample(12'h540, 1'b0); check("R3 high nibble at", pulse_o, 12'hFFF);
        sample(12'hF40, 1'b0); check("R3 upper data bits ignored", pulse_o, 12'hFFF);

        // R4: other addresses
        for (int a = 0; a < 32; a++) begin
            if (a != 2 && a != 3) reg_write(5'(a), 8'hFF);
        end
        sample(12'h53F, 1'b0); check("R4 foreign write below", pulse_o, 12'h000);
        sample(12'h540, 1'b0); check("R4 foreign write at", pulse_o, 12'hFFF);

        // R6: timing of the update
        @(negedge clk);
        acc_i = {12'h000, 12'h0}; step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        check("R6 no change before publish", pulse_o, 12'hFFF);
        @(negedge clk);
        check("R6 change after publish", pulse_o, 12'h000);
        acc_i = {12'hFFF, 12'h0};
        repeat (3) @(negedge clk);
        check("R6 hold without strobe", pulse_o, 12'h000);

        // R8: strobe during evaluation dropped
        @(negedge clk);
        acc_i = {12'h100, 12'h0}; step_i = 1'b1;
        @(negedge clk);
        acc_i = {12'hFFF, 12'h0};
        @(negedge clk);
        step_i = 1'b0;
        check("R8 second strobe ignored", pulse_o, 12'h000);
        repeat (2) @(negedge clk);
        check("R8 no late publish", pulse_o, 12'h000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule